// File: doc/BRIEF.md
# Smart Shutdown Line Controller

This block runs the shared active-low shutdown line of a half-bridge gate driver. That one line carries two things. It is an input that outside logic can pull low to stop switching. It is also an open-drain output that the block pulls low itself when the fault comparator trips.

When a fault arrives, the block removes the gate enable in the same cycle, through a combinational path. It does not wait for the line voltage to fall. In the next cycle it turns on the open-drain pull-down. It keeps the pull-down on only until the line is reported below the low input threshold. It then lets go, so that an external resistor and capacitor recharge the line. Switching resumes only after the line is reported above the high threshold. The time the gates stay off is therefore set by the external network alone, and the block adds no delay to the protection path.

Outside the fault sequence, the line level passes straight to the gate enable with hysteresis and is never latched. This lets a controller chop the PWM through the line. A fault that arrives while the supply is in undervoltage lockout is ignored.

Top module: `smart_sd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, gate_en_o and pulldown_o are 0. gate_en_o stays 0 until line_hi_i has been 1 at a rising clock edge. It becomes 1 in the cycle after that edge.
- R2: A trip is fault_i=1 while uvlo_i=0. During a trip, gate_en_o is 0 in the same cycle, whatever the line flags show.
- R3: After a clock edge that sees a trip, pulldown_o is 1. It stays 1 at every later edge while line_lo_i is 0, even after fault_i has returned to 0.
- R4: When pulldown_o is 1 and an edge sees line_lo_i=1 with no trip, pulldown_o is 0 after that edge, and gate_en_o stays 0.
- R5: After the pull-down has been released, gate_en_o stays 0 until an edge sees line_hi_i=1. It is 1 from the cycle after that edge, provided there is no trip.
- R6: In normal running, line_lo_i=1 forces gate_en_o to 0 in the same cycle, and line_hi_i=1 restores gate_en_o to 1 in the same cycle. The low level is not latched, and pulldown_o stays 0.
- R7: While line_lo_i and line_hi_i are both 0, the line level last decided is kept. gate_en_o keeps its previous value in normal running.
- R8: While uvlo_i=1, fault_i has no effect: gate_en_o keeps following the line and pulldown_o stays 0.
- R9: A trip restarts the pull-down from any state. This includes the wait for the high threshold, and a cycle in which line_lo_i=1 arrives together with the trip. In each case pulldown_o is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Synchronized fault comparator output, 1 = trip |
| uvlo_i | input | 1 | Supply undervoltage lockout, 1 = locked out |
| line_lo_i | input | 1 | Line below the low input threshold |
| line_hi_i | input | 1 | Line above the high input threshold |
| pulldown_o | output | 1 | Open-drain pull-down enable for the line |
| gate_en_o | output | 1 | Gate enable for both output stages; 0 holds both gates low |

## Verification
The bench checks the following corner cases; the expected failure of a wrong design is given with each:
- Gate enable in the trip cycle itself. A design that disabled the gates only through the registered state would leave them on for one cycle.
- The pull-down held with the fault already gone but the line still above the low threshold. A design that released it early would cut the disable time short.
- Release at the low threshold and recovery only at the high threshold. A design that recovered at the low threshold, or that did not distinguish the two thresholds, would re-enable the gates too soon.
- A retrip during the recovery wait, and a trip together with the low flag in the same cycle. A design that mishandled either would drop the pull-down.
- External chopping with the line between the thresholds. A design without hysteresis would turn the gates back on while the line is still between the thresholds.
- Masking of the fault in undervoltage. A wrong design would show a stray pull-down.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic [1:0] {
    SD_RUN  = 2'd0,
    SD_PULL = 2'd1,
    SD_WAIT = 2'd2
  } sd_state_e;
endpackage

// File: rtl/ssd_trip_qual.sv
module ssd_trip_qual (
  input  logic fault_i,
  input  logic uvlo_i,
  output logic trip_o
);
  // comparator is blind during undervoltage lockout
  assign trip_o = fault_i & ~uvlo_i;
endmodule

// File: rtl/ssd_line_level.sv
module ssd_line_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_lo_i,
  input  logic line_hi_i,
  output logic level_o
);
  logic level_q;

  // high flag dominates; neither flag keeps the last level
  always_comb begin
    if (line_hi_i)      level_o = 1'b1;
    else if (line_lo_i) level_o = 1'b0;
    else                level_o = level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_o;
  end
endmodule

// File: rtl/ssd_seq.sv
module ssd_seq
  import ssd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic line_lo_i,
  input  logic line_hi_i,
  output logic pulldown_o,
  output logic run_o
);
  sd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (trip_i) begin
      state_d = SD_PULL;
    end else begin
      unique case (state_q)
        SD_RUN:  state_d = SD_RUN;
        SD_PULL: if (line_lo_i) state_d = SD_WAIT;
        SD_WAIT: if (line_hi_i) state_d = SD_RUN;
        default: state_d = SD_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SD_WAIT;
    else         state_q <= state_d;
  end

  assign pulldown_o = (state_q == SD_PULL);
  assign run_o      = (state_q == SD_RUN);
endmodule

// File: rtl/smart_sd_ctrl.sv
module smart_sd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic uvlo_i,
  input  logic line_lo_i,
  input  logic line_hi_i,
  output logic pulldown_o,
  output logic gate_en_o
);
  logic trip, level, run;

  ssd_trip_qual u_trip (
    .fault_i (fault_i),
    .uvlo_i  (uvlo_i),
    .trip_o  (trip)
  );

  ssd_line_level u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_lo_i (line_lo_i),
    .line_hi_i (line_hi_i),
    .level_o   (level)
  );

  ssd_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_i     (trip),
    .line_lo_i  (line_lo_i),
    .line_hi_i  (line_hi_i),
    .pulldown_o (pulldown_o),
    .run_o      (run)
  );

  // fast path: trip kills gates without waiting for the line
  assign gate_en_o = run & level & ~trip;
endmodule

// File: rtl/smart_sd_ctrl_chk.sv
module smart_sd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fault_i,
  input logic uvlo_i,
  input logic line_lo_i,
  input logic line_hi_i,
  input logic pulldown_o,
  input logic gate_en_o
);
  // R2
  trip_kills_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !uvlo_i) |-> !gate_en_o);
  // R3
  pull_after_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !uvlo_i) |=> pulldown_o);
  // R3
  pull_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && !line_lo_i) |=> pulldown_o);
  // R4
  pull_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && line_lo_i && !(fault_i && !uvlo_i)) |=> !pulldown_o);
  // R4
  no_gate_in_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulldown_o |-> !gate_en_o);
  // R5
  gate_rise_needs_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |-> (line_hi_i || $past(line_hi_i)));
  // R6
  low_line_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_lo_i && !line_hi_i) |-> !gate_en_o);
  // R8
  uvlo_no_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulldown_o && uvlo_i) |=> !pulldown_o);
endmodule

bind smart_sd_ctrl smart_sd_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (fault_i),
  .uvlo_i     (uvlo_i),
  .line_lo_i  (line_lo_i),
  .line_hi_i  (line_hi_i),
  .pulldown_o (pulldown_o),
  .gate_en_o  (gate_en_o)
);

// File: tb/smart_sd_ctrl_tb.sv
module smart_sd_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault = 1'b0, uvlo = 1'b0, lo = 1'b0, hi = 1'b0;
  logic pd, gen;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smart_sd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .uvlo_i(uvlo),
    .line_lo_i(lo), .line_hi_i(hi), .pulldown_o(pd), .gate_en_o(gen)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic l, input logic h, input logic u);
    fault = f; lo = l; hi = h; uvlo = u;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1", gen, 1'b0, "gate in reset");
    chk("R1", pd, 1'b0, "pulldown in reset");
    tick(); rst_n = 1'b1; tick(); tick();
    chk("R1", gen, 1'b0, "gate before high threshold");
    chk("R1", pd, 1'b0, "pulldown idle");
    drive(0, 0, 1, 0);
    chk("R1", gen, 1'b0, "gate same cycle as first high");
    tick();
    chk("R1", gen, 1'b1, "gate after high seen");
    drive(0, 0, 0, 0); tick();
    chk("R7", gen, 1'b1, "mid band keeps high");
  endtask

  task automatic t_chop();
    drive(0, 1, 0, 0);
    chk("R6", gen, 1'b0, "external low drops gate");
    tick();
    chk("R6", pd, 1'b0, "no pulldown on external low");
    drive(0, 0, 0, 0); tick();
    chk("R7", gen, 1'b0, "mid band keeps low");
    drive(0, 0, 1, 0);
    chk("R6", gen, 1'b1, "high restores gate same cycle");
    tick();
    drive(0, 0, 0, 0); tick();
    chk("R6", gen, 1'b1, "gate stays after chop");
  endtask

  task automatic t_trip();
    drive(1, 0, 0, 0);
    chk("R2", gen, 1'b0, "gate off in trip cycle");
    chk("R3", pd, 1'b0, "pulldown not yet");
    tick();
    chk("R3", pd, 1'b1, "pulldown after trip");
    drive(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) tick();
    chk("R3", pd, 1'b1, "pulldown held above low threshold");
    chk("R3", gen, 1'b0, "gate off while pulled");
    drive(0, 0, 1, 0); tick();
    chk("R3", pd, 1'b1, "high flag does not release pull");
    drive(0, 1, 0, 0); tick();
    chk("R4", pd, 1'b0, "pull released at low threshold");
    chk("R4", gen, 1'b0, "gate off after release");
    drive(0, 0, 0, 0); tick();
    chk("R5", gen, 1'b0, "gate off in mid band while waiting");
    drive(0, 0, 1, 0);
    chk("R5", gen, 1'b0, "gate off same cycle high seen");
    tick();
    chk("R5", gen, 1'b1, "gate back after high");
  endtask

  task automatic t_retrip();
    drive(1, 0, 1, 0); tick();
    drive(0, 1, 0, 0); tick();
    chk("R9", pd, 1'b0, "released before retrip");
    drive(1, 0, 0, 0); tick();
    chk("R9", pd, 1'b1, "retrip in wait pulls again");
    drive(1, 1, 0, 0); tick();
    chk("R9", pd, 1'b1, "trip with low flag keeps pull");
    drive(0, 1, 0, 0); tick();
    chk("R4", pd, 1'b0, "release after retrip");
    drive(0, 0, 1, 0); tick();
    chk("R5", gen, 1'b1, "recovered after retrip");
  endtask

  task automatic t_uvlo();
    drive(1, 0, 1, 1);
    chk("R8", gen, 1'b1, "fault ignored in uvlo, gate");
    tick(); tick();
    chk("R8", pd, 1'b0, "fault ignored in uvlo, pulldown");
    chk("R8", gen, 1'b1, "gate still following line");
    drive(1, 1, 0, 1);
    chk("R8", gen, 1'b0, "line still controls gate in uvlo");
    drive(0, 0, 1, 0); tick();
  endtask

  initial begin
    t_reset();
    t_chop();
    t_trip();
    t_retrip();
    t_uvlo();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule